// File: doc/BRIEF.md
# Clock-Synthesiser Configuration Register Bank

This block is a two-wire serial target (I2C) that holds the configuration bytes of a clock-synthesis controller. It also serves the read-only identity and lock-status bytes of that controller to the bus. It answers the 7-bit device address `010011S`, where `S` is the level of a board strap input. A host can write one register or a run of consecutive registers in a single transfer. It reads registers by first writing the register index and then issuing a repeated START with the read bit set. The register index advances after every byte moved in either direction.

Eight configuration bytes live at indices 0 to 7. Indices 1, 2 and 3 hold the loop and feedback-divider settings, and index 5 holds the phase-adjust resolution. Each of these four is staged: a bus write lands in a staging copy, and the copy that drives the rest of the chip changes only when a command byte is written to index 8. The upper nibble of that command commits the loop group and the lower nibble commits the phase-adjust group. The other configuration bytes take effect as soon as they are written. SCL and SDA arrive asynchronously and are synchronised to the system clock. START and STOP are recognised as SDA edges while SCL is high.

Top module: `clksyn_cfg_bank`

## Requirements
- R1: The block acknowledges a device address byte only when its upper seven bits equal `{6'b010011, addr_sel}`. Any other address gets no acknowledge, and the rest of that transfer has no effect on any register.
- R2: A write transfer is START, address with bit 0 = 0, register index, one data byte, STOP. It stores the data byte at that index. Indices 0, 4, 6 and 7 appear on their output ports once the transfer completes.
- R3: Data bytes that follow one another in a single write transfer go to consecutive indices, starting at the index byte. The index wraps from FFh to 00h.
- R4: After a written index, a repeated START and the address with bit 0 = 1 make the block shift out the byte at that index, MSB first. Each byte the host acknowledges is followed by the byte at the next index. A NACK ends the read.
- R5: Writes to indices 1, 2 and 3 leave `cfg_loop`, `cfg_fbdiv_lo` and `cfg_fbdiv_hi` unchanged. Those outputs take the staged values only when a byte with upper nibble 5h is written to index 8.
- R6: A write to index 5 leaves `cfg_dpa` unchanged. `cfg_dpa` takes the staged value only when a byte with lower nibble Ah is written to index 8. The byte 5Ah commits both groups, and a command byte matching neither nibble commits nothing.
- R7: After reset the configuration bytes at indices 0 to 7 are 41h, 00h, FFh, 0Fh, 80h, 03h, 1Fh and 80h. The same values are on the outputs.
- R8: Index 10h reads the version byte (default 18h) and index 11h reads the revision byte (default 01h). Index 12h reads `{6'b0, pll_lock, dpa_lock}`: bit 1 is PLL lock and bit 0 is phase-adjust lock, each seen after two clocks of synchronisation.
- R9: Writes to indices other than 0 to 8 are acknowledged and change nothing. Reads of indices other than 0 to 7 and 10h to 12h return 00h. The index still advances past them in both directions.
- R10: A STOP or START that arrives in the middle of a data byte discards the partial byte, and no register changes.
- R11: Reading indices 1, 2, 3 and 5 returns the staged value, not the working copy. Bits 7:4 of index 3 always read 0 and are not stored. Index 8 reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (open-drain drive) |
| addr_sel | input | 1 | Strap selecting the lowest device-address bit |
| pll_lock | input | 1 | PLL lock status from the analog section |
| dpa_lock | input | 1 | Phase-adjust lock status |
| cfg_input | output | 8 | Index 0: input control byte |
| cfg_loop | output | 8 | Working copy of index 1: loop control |
| cfg_fbdiv_lo | output | 8 | Working copy of index 2: feedback divider bits 7:0 |
| cfg_fbdiv_hi | output | 4 | Working copy of index 3: feedback divider bits 11:8 |
| cfg_phase | output | 8 | Index 4: phase offset and filter select |
| cfg_dpa | output | 8 | Working copy of index 5: phase-adjust resolution |
| cfg_outen | output | 8 | Index 6: output enables and scaler |
| cfg_osc | output | 8 | Index 7: oscillator divider and input select |

## Verification
The bench builds the block with its default parameters: device address high bits 010011, two synchroniser stages, version 18h and revision 01h. With these values both strap settings can be driven, and the identity bytes can be checked against fixed constants. The bus runs at one fortieth of the system clock, which leaves room for the synchroniser and edge-detect delay before every SCL edge. That keeps every bit slot within reach, including the ACK hand-over and the repeated START straight after an index byte. Random mixes of writes, commit commands and reads cover index wrap, reserved indices and lock-status changes.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    localparam int BYTE_W   = 8;
    localparam int NUM_CFG  = 8;
    localparam int IDX_W    = $clog2(NUM_CFG);

    localparam logic [BYTE_W-1:0] IDX_CMD  = 8'h08;
    localparam logic [BYTE_W-1:0] IDX_VER  = 8'h10;
    localparam logic [BYTE_W-1:0] IDX_REV  = 8'h11;
    localparam logic [BYTE_W-1:0] IDX_STAT = 8'h12;

    localparam logic [3:0] PLL_KEY = 4'h5;
    localparam logic [3:0] DPA_KEY = 4'hA;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TXACK
    } xfer_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_INDEX,
        PH_DATA,
        PH_READ
    } xfer_phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic  en;
        byte_t idx;
        byte_t data;
    } wr_req_t;

    function automatic byte_t cfg_reset(int unsigned i);
        case (i)
            0:       return 8'h41;
            1:       return 8'h00;
            2:       return 8'hFF;
            3:       return 8'h0F;
            4:       return 8'h80;
            5:       return 8'h03;
            6:       return 8'h1F;
            7:       return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    function automatic byte_t cfg_wmask(int unsigned i);
        return (i == 3) ? 8'h0F : 8'hFF;
    endfunction

    function automatic logic in_pll_group(int unsigned i);
        return (i >= 1) && (i <= 3);
    endfunction

    function automatic logic in_dpa_group(int unsigned i);
        return (i == 5);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import cfgbank_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_comb begin
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
        evt.sda      = sda_s;
    end

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import cfgbank_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR_HI = 6'b010011
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt,
    input  logic     addr_sel,
    input  byte_t    rd_data,
    output byte_t    rd_idx,
    output wr_req_t  wr,
    output logic     sda_oe
);

    xfer_state_e state;
    xfer_phase_e phase;
    byte_t       shreg;
    byte_t       idx;
    logic [3:0]  cnt;
    logic        rw;
    logic        acked;

    assign rd_idx = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            phase <= PH_ADDR;
            shreg <= '0;
            idx   <= '0;
            cnt   <= '0;
            rw    <= 1'b0;
            acked <= 1'b0;
            wr    <= '0;
        end else begin
            wr.en <= 1'b0;
            if (evt.start) begin
                state <= ST_RX;
                phase <= PH_ADDR;
                cnt   <= '0;
            end else if (evt.stop) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_RX: begin
                        if (evt.scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], evt.sda};
                            cnt   <= cnt + 4'd1;
                        end else if (evt.scl_fall && cnt == 4'd8) begin
                            cnt <= '0;
                            case (phase)
                                PH_ADDR: begin
                                    if (shreg[7:1] == {DEV_ADDR_HI, addr_sel}) begin
                                        rw    <= shreg[0];
                                        state <= ST_ACK;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                PH_INDEX: begin
                                    idx   <= shreg;
                                    state <= ST_ACK;
                                end
                                default: begin
                                    wr.en   <= 1'b1;
                                    wr.idx  <= idx;
                                    wr.data <= shreg;
                                    idx     <= idx + 8'd1;
                                    state   <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (evt.scl_fall) begin
                            cnt <= '0;
                            case (phase)
                                PH_ADDR: begin
                                    if (rw) begin
                                        shreg <= rd_data;
                                        idx   <= idx + 8'd1;
                                        phase <= PH_READ;
                                        state <= ST_TX;
                                    end else begin
                                        phase <= PH_INDEX;
                                        state <= ST_RX;
                                    end
                                end
                                PH_INDEX: begin
                                    phase <= PH_DATA;
                                    state <= ST_RX;
                                end
                                default: state <= ST_RX;
                            endcase
                        end
                    end
                    ST_TX: begin
                        if (evt.scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (evt.scl_fall) begin
                            if (cnt == 4'd8) begin
                                cnt   <= '0;
                                state <= ST_TXACK;
                            end else begin
                                shreg <= {shreg[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (evt.scl_rise) begin
                            acked <= ~evt.sda;
                        end else if (evt.scl_fall) begin
                            if (acked) begin
                                shreg <= rd_data;
                                idx   <= idx + 8'd1;
                                state <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe = (state == ST_ACK) || ((state == ST_TX) && !shreg[BYTE_W-1]);

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfgbank_pkg::*;
#(
    parameter byte_t VERSION     = 8'h18,
    parameter byte_t REVISION    = 8'h01,
    parameter int    SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  wr_req_t                       wr,
    input  byte_t                         rd_idx,
    input  logic                          pll_lock,
    input  logic                          dpa_lock,
    output byte_t                         rd_data,
    output logic [NUM_CFG-1:0][BYTE_W-1:0] work_q,
    output logic                          pll_commit,
    output logic                          dpa_commit
);

    logic [NUM_CFG-1:0][BYTE_W-1:0] stage_q;
    logic [SYNC_STAGES-1:0]         pll_p;
    logic [SYNC_STAGES-1:0]         dpa_p;
    logic                           cmd_wr;

    assign cmd_wr     = wr.en && (wr.idx == IDX_CMD);
    assign pll_commit = cmd_wr && (wr.data[7:4] == PLL_KEY);
    assign dpa_commit = cmd_wr && (wr.data[3:0] == DPA_KEY);

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        byte_t st;
        always_ff @(posedge clk) begin
            if (rst)
                st <= cfg_reset(g);
            else if (wr.en && wr.idx == byte_t'(g))
                st <= wr.data & cfg_wmask(g);
        end
        assign stage_q[g] = st;

        if (in_pll_group(g) || in_dpa_group(g)) begin : g_staged
            byte_t wk;
            logic  commit;
            assign commit = in_pll_group(g) ? pll_commit : dpa_commit;
            always_ff @(posedge clk) begin
                if (rst)
                    wk <= cfg_reset(g);
                else if (commit)
                    wk <= st;
            end
            assign work_q[g] = wk;
        end else begin : g_live
            assign work_q[g] = st;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pll_p <= '0;
            dpa_p <= '0;
        end else begin
            pll_p <= {pll_p[SYNC_STAGES-2:0], pll_lock};
            dpa_p <= {dpa_p[SYNC_STAGES-2:0], dpa_lock};
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_idx < byte_t'(NUM_CFG)) begin
            rd_data = stage_q[rd_idx[IDX_W-1:0]];
        end else begin
            case (rd_idx)
                IDX_VER:  rd_data = VERSION;
                IDX_REV:  rd_data = REVISION;
                IDX_STAT: rd_data = {6'b0, pll_p[SYNC_STAGES-1], dpa_p[SYNC_STAGES-1]};
                default:  rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/clksyn_cfg_bank.sv
module clksyn_cfg_bank
    import cfgbank_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR_HI = 6'b010011,
    parameter byte_t      VERSION     = 8'h18,
    parameter byte_t      REVISION    = 8'h01,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic       addr_sel,
    input  logic       pll_lock,
    input  logic       dpa_lock,
    output logic [7:0] cfg_input,
    output logic [7:0] cfg_loop,
    output logic [7:0] cfg_fbdiv_lo,
    output logic [3:0] cfg_fbdiv_hi,
    output logic [7:0] cfg_phase,
    output logic [7:0] cfg_dpa,
    output logic [7:0] cfg_outen,
    output logic [7:0] cfg_osc
);

    bus_evt_t                       evt;
    wr_req_t                        wr_req;
    byte_t                          rd_idx;
    byte_t                          rd_data;
    logic [NUM_CFG-1:0][BYTE_W-1:0] work_q;
    logic                           pll_commit;
    logic                           dpa_commit;
    logic                           wr_en_w;
    logic [3:0]                     fb_hi_spare;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    i2c_target_fsm #(.DEV_ADDR_HI(DEV_ADDR_HI)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .addr_sel (addr_sel),
        .rd_data  (rd_data),
        .rd_idx   (rd_idx),
        .wr       (wr_req),
        .sda_oe   (sda_oe)
    );

    cfg_regfile #(
        .VERSION     (VERSION),
        .REVISION    (REVISION),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr_req),
        .rd_idx     (rd_idx),
        .pll_lock   (pll_lock),
        .dpa_lock   (dpa_lock),
        .rd_data    (rd_data),
        .work_q     (work_q),
        .pll_commit (pll_commit),
        .dpa_commit (dpa_commit)
    );

    assign wr_en_w      = wr_req.en;
    assign cfg_input    = work_q[0];
    assign cfg_loop     = work_q[1];
    assign cfg_fbdiv_lo = work_q[2];
    assign {fb_hi_spare, cfg_fbdiv_hi} = work_q[3];
    assign cfg_phase    = work_q[4];
    assign cfg_dpa      = work_q[5];
    assign cfg_outen    = work_q[6];
    assign cfg_osc      = work_q[7];

endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_in,
    input logic       sda_oe,
    input logic       wr_en,
    input logic       pll_commit,
    input logic       dpa_commit,
    input logic [7:0] cfg_input,
    input logic [7:0] cfg_loop,
    input logic [7:0] cfg_fbdiv_lo,
    input logic [3:0] cfg_fbdiv_hi,
    input logic [7:0] cfg_dpa,
    input logic [3:0] fb_hi_spare
);

    // R5
    pll_group_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pll_commit |=> $stable({cfg_loop, cfg_fbdiv_lo, cfg_fbdiv_hi}));

    // R6
    dpa_group_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !dpa_commit |=> $stable(cfg_dpa));

    // R7
    reset_value_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cfg_input == 8'h41 && cfg_fbdiv_lo == 8'hFF && cfg_fbdiv_hi == 4'hF));

    // R4
    sda_steady_while_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_in && $past(scl_in) && $past(scl_in, 2) && $past(scl_in, 3) && $past(scl_in, 4))
        |-> $stable(sda_oe));

    // R9
    write_acked_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> sda_oe);

    // R11
    fb_hi_spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
        fb_hi_spare == 4'h0);

endmodule

bind clksyn_cfg_bank cfg_bank_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .scl_in       (scl_in),
    .sda_oe       (sda_oe),
    .wr_en        (wr_en_w),
    .pll_commit   (pll_commit),
    .dpa_commit   (dpa_commit),
    .cfg_input    (cfg_input),
    .cfg_loop     (cfg_loop),
    .cfg_fbdiv_lo (cfg_fbdiv_lo),
    .cfg_fbdiv_hi (cfg_fbdiv_hi),
    .cfg_dpa      (cfg_dpa),
    .fb_hi_spare  (fb_hi_spare)
);

// File: tb/clksyn_cfg_bank_bench.sv
module clksyn_cfg_bank_bench;

    localparam int Q = 10;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst      = 1'b1;
    logic scl_m    = 1'b1;
    logic sda_m    = 1'b1;
    logic addr_sel = 1'b0;
    logic pll_lock = 1'b0;
    logic dpa_lock = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic [7:0] cfg_input, cfg_loop, cfg_fbdiv_lo, cfg_phase, cfg_dpa, cfg_outen, cfg_osc;
    logic [3:0] cfg_fbdiv_hi;

    assign sda_line = sda_m & ~sda_oe;

    clksyn_cfg_bank u_clksyn_cfg_bank (
        .clk          (clk),
        .rst          (rst),
        .scl_in       (scl_m),
        .sda_in       (sda_line),
        .sda_oe       (sda_oe),
        .addr_sel     (addr_sel),
        .pll_lock     (pll_lock),
        .dpa_lock     (dpa_lock),
        .cfg_input    (cfg_input),
        .cfg_loop     (cfg_loop),
        .cfg_fbdiv_lo (cfg_fbdiv_lo),
        .cfg_fbdiv_hi (cfg_fbdiv_hi),
        .cfg_phase    (cfg_phase),
        .cfg_dpa      (cfg_dpa),
        .cfg_outen    (cfg_outen),
        .cfg_osc      (cfg_osc)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] m_stage [0:7];
    logic [7:0] m_w1, m_w2, m_w3, m_w5;
    logic [7:0] wbuf [0:7];

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dev_w();
        return {6'b010011, addr_sel, 1'b0};
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] i);
        if (i < 8'd8) return m_stage[i[2:0]];
        case (i)
            8'h10:   return 8'h18;
            8'h11:   return 8'h01;
            8'h12:   return {6'b0, pll_lock, dpa_lock};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_wr(input logic [7:0] i, input logic [7:0] b);
        if (i < 8'd8) begin
            m_stage[i[2:0]] = (i == 8'd3) ? (b & 8'h0F) : b;
        end else if (i == 8'd8) begin
            if (b[7:4] == 4'h5) begin
                m_w1 = m_stage[1];
                m_w2 = m_stage[2];
                m_w3 = m_stage[3];
            end
            if (b[3:0] == 4'hA) m_w5 = m_stage[5];
        end
    endtask

    task automatic put_bit(input logic b);
        tick(Q); sda_m = b; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(2 * Q); scl_m = 1'b1; tick(Q); b = sda_line; tick(Q); scl_m = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack_n);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(ack_n);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) get_bit(b[i]);
        put_bit(nack);
    endtask

    task automatic wr_txn(input logic [7:0] dev, input logic [7:0] idx, input int n, input string req);
        logic a;
        logic match;
        match = (dev[7:1] == {6'b010011, addr_sel});
        bus_start();
        send_byte(dev, a);
        chk(req, a, match ? 1'b0 : 1'b1);
        if (match) begin
            send_byte(idx, a);
            chk(req, a, 1'b0);
            for (int i = 0; i < n; i++) begin
                send_byte(wbuf[i], a);
                chk(req, a, 1'b0);
                model_wr(idx + 8'(i), wbuf[i]);
            end
        end
        bus_stop();
    endtask

    task automatic rd_txn(input logic [7:0] idx, input int n, input string req);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(dev_w(), a);
        chk(req, a, 1'b0);
        send_byte(idx, a);
        chk(req, a, 1'b0);
        bus_start();
        send_byte(dev_w() | 8'h01, a);
        chk(req, a, 1'b0);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, b);
            chk(req, b, exp_rd(idx + 8'(i)));
        end
        bus_stop();
    endtask

    task automatic check_outs(input string req);
        chk(req, cfg_input, m_stage[0]);
        chk(req, cfg_loop, m_w1);
        chk(req, cfg_fbdiv_lo, m_w2);
        chk(req, cfg_fbdiv_hi, m_w3[3:0]);
        chk(req, cfg_phase, m_stage[4]);
        chk(req, cfg_dpa, m_w5);
        chk(req, cfg_outen, m_stage[6]);
        chk(req, cfg_osc, m_stage[7]);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic a;
        void'($urandom(32'd1524));
        m_stage[0] = 8'h41; m_stage[1] = 8'h00; m_stage[2] = 8'hFF; m_stage[3] = 8'h0F;
        m_stage[4] = 8'h80; m_stage[5] = 8'h03; m_stage[6] = 8'h1F; m_stage[7] = 8'h80;
        m_w1 = 8'h00; m_w2 = 8'hFF; m_w3 = 8'h0F; m_w5 = 8'h03;

        tick(5);
        rst = 1'b0;
        tick(5);

        // R7: reset values on ports and on readback
        check_outs("R7");
        rd_txn(8'h00, 8, "R7");
        // R11: command index reads zero
        rd_txn(8'h08, 1, "R11");

        // R1: other strap address is not acknowledged and writes nothing
        wbuf[0] = 8'hA5;
        wr_txn(8'h4E, 8'h00, 1, "R1");
        check_outs("R1");
        addr_sel = 1'b1;
        wbuf[0] = 8'h3C;
        wr_txn(8'h4E, 8'h07, 1, "R1");
        check_outs("R1");
        wbuf[0] = 8'h99;
        wr_txn(8'h4C, 8'h07, 1, "R1");
        check_outs("R1");
        addr_sel = 1'b0;

        // R2: single write to a live register
        wbuf[0] = 8'hC3;
        wr_txn(dev_w(), 8'h00, 1, "R2");
        check_outs("R2");

        // R3: sequential write 4..7 (R6: index 5 stays staged)
        wbuf[0] = 8'h2A; wbuf[1] = 8'h01; wbuf[2] = 8'h15; wbuf[3] = 8'h7F;
        wr_txn(dev_w(), 8'h04, 4, "R3");
        check_outs("R3");
        chk("R6", cfg_dpa, 8'h03);

        // R5: staged loop group
        wbuf[0] = 8'h25; wbuf[1] = 8'h34; wbuf[2] = 8'hF7;
        wr_txn(dev_w(), 8'h01, 3, "R5");
        check_outs("R5");
        chk("R5", cfg_fbdiv_lo, 8'hFF);
        // R11: staged values read back, index 3 upper nibble dropped
        rd_txn(8'h01, 5, "R11");
        wbuf[0] = 8'h33;
        wr_txn(dev_w(), 8'h08, 1, "R6");
        check_outs("R6");
        wbuf[0] = 8'h53;
        wr_txn(dev_w(), 8'h08, 1, "R5");
        check_outs("R5");
        chk("R5", cfg_fbdiv_hi, 4'h7);
        chk("R6", cfg_dpa, 8'h03);
        wbuf[0] = 8'hAA;
        wr_txn(dev_w(), 8'h08, 1, "R6");
        check_outs("R6");
        chk("R6", cfg_dpa, 8'h01);
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h03; wbuf[3] = 8'h44; wbuf[4] = 8'h02;
        wr_txn(dev_w(), 8'h01, 5, "R6");
        wbuf[0] = 8'h5A;
        wr_txn(dev_w(), 8'h08, 1, "R6");
        check_outs("R6");
        chk("R6", cfg_dpa, 8'h02);

        // R8: identity and status bytes
        pll_lock = 1'b1; dpa_lock = 1'b0;
        tick(5);
        rd_txn(8'h10, 3, "R8");
        pll_lock = 1'b0; dpa_lock = 1'b1;
        tick(5);
        rd_txn(8'h12, 1, "R8");

        // R9: read-only / unimplemented writes ignored, index wraps (R3)
        wbuf[0] = 8'hEE; wbuf[1] = 8'hEE; wbuf[2] = 8'hEE;
        wr_txn(dev_w(), 8'h10, 3, "R9");
        rd_txn(8'h0E, 5, "R9");
        wbuf[0] = 8'h11; wbuf[1] = 8'h6B;
        wr_txn(dev_w(), 8'hFF, 2, "R9");
        check_outs("R9");
        chk("R3", cfg_input, 8'h6B);

        // R10: STOP in the middle of a data byte
        bus_start();
        send_byte(dev_w(), a);
        send_byte(8'h04, a);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_stop();
        check_outs("R10");
        // R10: START in the middle of a data byte, then a full read
        bus_start();
        send_byte(dev_w(), a);
        send_byte(8'h06, a);
        put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
        tick(Q); sda_m = 1'b1;
        bus_start();
        send_byte(dev_w() | 8'h01, a);
        chk("R10", a, 1'b0);
        begin
            logic [7:0] b;
            recv_byte(1'b1, b);
            chk("R10", b, m_stage[6]);
        end
        bus_stop();
        check_outs("R10");

        // Random mix (R3, R4, R5, R6)
        for (int t = 0; t < 30; t++) begin
            int kind;
            int n;
            logic [7:0] idx;
            kind = int'($urandom % 4);
            n    = 1 + int'($urandom % 3);
            if (kind < 2) begin
                idx = 8'($urandom % 10);
                for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
                wr_txn(dev_w(), idx, n, "R3");
            end else if (kind == 2) begin
                case ($urandom % 4)
                    0: wbuf[0] = {4'h5, 4'($urandom % 10)};
                    1: wbuf[0] = {4'($urandom % 5), 4'hA};
                    2: wbuf[0] = 8'h5A;
                    default: wbuf[0] = 8'($urandom);
                endcase
                wr_txn(dev_w(), 8'h08, 1, "R5");
            end else begin
                pll_lock = 1'($urandom);
                dpa_lock = 1'($urandom);
                tick(5);
                rd_txn(8'($urandom % 20), n, "R4");
            end
            check_outs("R6");
        end

        summary();
        $finish;
    end

endmodule